// File: doc/BRIEF.md
# Windowed Carrier Presence Detector

This block decides whether a carrier of the expected frequency is present on a receive line. Two threshold flags come from an analog front end. One flag says the input is above the upper threshold and the other says it is below the lower threshold. The block synchronizes both flags and builds a squared signal from them that switches only on a clear crossing. It then times every cycle of that signal in clock periods.

A cycle counts as valid only when its length falls in a narrow window around sixteen clocks. A rising edge that takes too long to arrive counts as an invalid cycle. The detect output is active low. It asserts only after an unbroken run of valid cycles, and it releases only after an unbroken run of invalid or missing cycles. Short bursts of noise or brief dropouts therefore do not toggle it.

Top module: `carrier_window_detect`

## Requirements
- R1: While `rst` is high on a clock edge, `carrier_n` becomes 1, both run counters clear, the squared signal goes to 0 and the next rising edge starts a measurement without being judged.
- R2: After a two-flop synchronizer, `above_hi` alone drives the squared signal to 0 and `below_lo` alone drives it to 1; when neither flag or both flags are set, the squared signal keeps its value.
- R3: The length of a cycle is the number of clocks from one rising edge of the squared signal to the next, whatever the duty cycle.
- R4: With defaults, a measured length of 15, 16 or 17 clocks is valid and every other length is invalid.
- R5: If 18 clocks pass after a rising edge (or after reset, or after the previous timeout) with no new rising edge, that interval counts as one invalid cycle and timing restarts. The first rising edge after a timeout only starts a new measurement.
- R6: `carrier_n` falls to 0 on the 12th valid cycle in a row, within five clock edges of the flag change that completes that cycle.
- R7: `carrier_n` rises to 1 on the 12th invalid cycle in a row, counting timeouts.
- R8: A valid cycle clears the invalid run, and an invalid cycle clears the valid run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; every cycle length is measured in it |
| rst | input | 1 | Synchronous active-high reset |
| above_hi | input | 1 | Asynchronous flag: input is above the upper threshold |
| below_lo | input | 1 | Asynchronous flag: input is below the lower threshold |
| carrier_n | output | 1 | Registered detect flag, 0 while a carrier is confirmed |

## Verification
The bench sweeps every cycle length from 10 to 20 clocks, both when gaining and when losing the carrier. A window that is off by one clock at either end flips the result for 14, 15, 17 or 18 clocks. Run-length boundaries are tested at exactly 11 and 12 cycles, both for gaining and for losing, and a counter that is off by one shows up at that boundary. The unjudged first edge after reset or timeout is tested at the same boundary: a design that judges that edge detects one cycle early. Runs broken by a single opposite cycle must restart the count, so a design that fails to clear the opposite counter confirms too early. Cycles padded with held and both-flag intervals must give exactly the same result as clean ones; a latch that does not hold, or that favours one flag, creates extra edges and loses the carrier.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  // Outcome of one measured interval
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_VALID   = 2'd1,
    EV_INVALID = 2'd2
  } period_ev_t;
endpackage

// File: rtl/cpd_shaper.sv
// Synchronizes the threshold flags and keeps a set/clear/hold level.
module cpd_shaper #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_flag,
  input  logic lo_flag,
  output logic hi_s,
  output logic lo_s,
  output logic sq,
  output logic rise
);
  logic [SYNC_STAGES-1:0] hi_pipe;
  logic [SYNC_STAGES-1:0] lo_pipe;
  logic                   sq_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_pipe <= '0;
      lo_pipe <= '0;
    end else begin
      hi_pipe[0] <= hi_flag;
      lo_pipe[0] <= lo_flag;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        hi_pipe[i] <= hi_pipe[i-1];
        lo_pipe[i] <= lo_pipe[i-1];
      end
    end
  end

  assign hi_s = hi_pipe[SYNC_STAGES-1];
  assign lo_s = lo_pipe[SYNC_STAGES-1];

  // Upper crossing pulls the level low, lower crossing pushes it high.
  always_ff @(posedge clk) begin
    if (rst) begin
      sq   <= 1'b0;
      sq_d <= 1'b0;
    end else begin
      sq_d <= sq;
      if (hi_s && !lo_s)
        sq <= 1'b0;
      else if (lo_s && !hi_s)
        sq <= 1'b1;
    end
  end

  assign rise = sq & ~sq_d;
endmodule

// File: rtl/cpd_period.sv
// Times intervals between rising edges and classifies them.
module cpd_period
  import cpd_pkg::*;
#(
  parameter int MIN_P   = 15,
  parameter int MAX_P   = 17,
  parameter int TIMEOUT = MAX_P + 1,
  localparam int CW     = $clog2(TIMEOUT + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  output logic [CW-1:0] cnt,
  output period_ev_t ev
);
  localparam logic [CW-1:0] LO_LAST = CW'(MIN_P - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(MAX_P - 1);
  localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT - 1);

  logic armed;
  logic in_window;

  assign in_window = (cnt >= LO_LAST) && (cnt <= HI_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
      ev    <= EV_NONE;
    end else begin
      ev <= EV_NONE;
      if (rise) begin
        cnt   <= '0;
        armed <= 1'b1;
        if (armed)
          ev <= in_window ? EV_VALID : EV_INVALID;
      end else if (cnt == TO_LAST) begin
        cnt   <= '0;
        armed <= 1'b0;
        ev    <= EV_INVALID;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpd_judge.sv
// Consecutive-run confirmation in both directions.
module cpd_judge
  import cpd_pkg::*;
#(
  parameter int RUN_LEN = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  period_ev_t ev,
  output logic       det_n
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(RUN_LEN);

  logic [RW-1:0] vrun;
  logic [RW-1:0] irun;

  always_ff @(posedge clk) begin
    if (rst) begin
      vrun  <= '0;
      irun  <= '0;
      det_n <= 1'b1;
    end else begin
      unique case (ev)
        EV_VALID: begin
          irun <= '0;
          if (vrun != RUN_FULL) vrun <= vrun + 1'b1;
          if (vrun >= RUN_LAST) det_n <= 1'b0;
        end
        EV_INVALID: begin
          vrun <= '0;
          if (irun != RUN_FULL) irun <= irun + 1'b1;
          if (irun >= RUN_LAST) det_n <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/carrier_window_detect.sv
module carrier_window_detect
  import cpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_P       = 15,
  parameter int MAX_P       = 17,
  parameter int TIMEOUT     = MAX_P + 1,
  parameter int RUN_LEN     = 12,
  localparam int CW         = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic above_hi,
  input  logic below_lo,
  output logic carrier_n
);
  logic          hi_s;
  logic          lo_s;
  logic          sq;
  logic          rise;
  logic [CW-1:0] per_cnt;
  period_ev_t    ev;
  logic          ev_valid;
  logic          ev_invalid;

  cpd_shaper #(.SYNC_STAGES(SYNC_STAGES)) shaper_i (
    .clk(clk), .rst(rst), .hi_flag(above_hi), .lo_flag(below_lo),
    .hi_s(hi_s), .lo_s(lo_s), .sq(sq), .rise(rise)
  );

  cpd_period #(.MIN_P(MIN_P), .MAX_P(MAX_P), .TIMEOUT(TIMEOUT)) period_i (
    .clk(clk), .rst(rst), .rise(rise), .cnt(per_cnt), .ev(ev)
  );

  cpd_judge #(.RUN_LEN(RUN_LEN)) judge_i (
    .clk(clk), .rst(rst), .ev(ev), .det_n(carrier_n)
  );

  assign ev_valid   = (ev == EV_VALID);
  assign ev_invalid = (ev == EV_INVALID);
endmodule

// File: rtl/carrier_window_detect_chk.sv
module carrier_window_detect_chk #(
  parameter int MIN_P   = 15,
  parameter int MAX_P   = 17,
  parameter int TIMEOUT = 18,
  parameter int CW      = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          carrier_n,
  input logic          hi_s,
  input logic          lo_s,
  input logic          sq,
  input logic          rise,
  input logic [CW-1:0] per_cnt,
  input logic          ev_valid,
  input logic          ev_invalid
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> carrier_n);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (hi_s == lo_s) |=> $stable(sq));

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (hi_s && !lo_s) |=> !sq);

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (lo_s && !hi_s) |=> sq);

  p_window_r4: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (($past(per_cnt) + 1 >= MIN_P) && ($past(per_cnt) + 1 <= MAX_P)));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    per_cnt <= CW'(TIMEOUT - 1));

  p_timeout_r5: assert property (@(posedge clk) disable iff (rst)
    (per_cnt == CW'(TIMEOUT - 1) && !rise) |=> ev_invalid);

  p_fall_on_valid_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(carrier_n) |-> $past(ev_valid));

  p_rise_on_invalid_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(carrier_n) |-> $past(ev_invalid));
endmodule

bind carrier_window_detect carrier_window_detect_chk #(
  .MIN_P(MIN_P), .MAX_P(MAX_P), .TIMEOUT(TIMEOUT), .CW(CW)
) chk_i (
  .clk(clk), .rst(rst), .carrier_n(carrier_n), .hi_s(hi_s), .lo_s(lo_s),
  .sq(sq), .rise(rise), .per_cnt(per_cnt), .ev_valid(ev_valid),
  .ev_invalid(ev_invalid)
);

// File: tb/carrier_window_detect_tb.sv
module carrier_window_detect_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic above_hi = 1'b0;
  logic below_lo = 1'b0;
  logic carrier_n;
  int   checks = 0;
  int   errors = 0;

  always #5 clk = ~clk;

  carrier_window_detect dut_i (
    .clk(clk), .rst(rst), .above_hi(above_hi), .below_lo(below_lo),
    .carrier_n(carrier_n)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (carrier_n !== exp) begin
      errors++;
      $display("FAIL %s: carrier_n=%b expected=%b at %0t", req, carrier_n, exp, $time);
    end
  endtask

  task automatic hold_cycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; above_hi = 1'b0; below_lo = 1'b0;
    hold_cycles(3);
    rst = 1'b0;
  endtask

  // One cycle per call: upper phase first, then lower phase (rising edge there).
  task automatic wave(input int p, input int n, input int lo_len = 8);
    for (int i = 0; i < n; i++) begin
      above_hi = 1'b1; below_lo = 1'b0; hold_cycles(p - lo_len);
      above_hi = 1'b0; below_lo = 1'b1; hold_cycles(lo_len);
    end
  endtask

  // 16-clock cycle with held and both-flag stretches inside each phase.
  task automatic gap_wave(input int n);
    for (int i = 0; i < n; i++) begin
      above_hi = 1'b1; below_lo = 1'b0; hold_cycles(2);
      above_hi = 1'b1; below_lo = 1'b1; hold_cycles(3);
      above_hi = 1'b0; below_lo = 1'b0; hold_cycles(3);
      above_hi = 1'b0; below_lo = 1'b1; hold_cycles(2);
      above_hi = 1'b1; below_lo = 1'b1; hold_cycles(3);
      above_hi = 1'b0; below_lo = 1'b1; hold_cycles(3);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    hold_cycles(2);
    check(1'b1, "R1 reset state");

    // R6 boundary: first edge unjudged, so 12 calls = 11 valid cycles
    do_reset(); wave(16, 12);
    check(1'b1, "R6 eleven valid cycles");
    wave(16, 1);
    check(1'b0, "R6 twelfth valid cycle");

    // R4 sweep of cycle lengths while acquiring
    for (int p = 10; p <= 20; p++) begin
      do_reset(); wave(p, 30);
      check((p >= 15 && p <= 17) ? 1'b0 : 1'b1, $sformatf("R4 acquire length %0d", p));
    end

    // R3 duty independence
    for (int lo = 6; lo <= 13; lo += 7) begin
      do_reset(); wave(16, 13, lo);
      check(1'b0, $sformatf("R3 duty lo=%0d", lo));
    end

    // R7 loss by silence (timeouts every 18 clocks)
    do_reset(); wave(16, 13);
    above_hi = 1'b0; below_lo = 1'b0;
    hold_cycles(203);
    check(1'b0, "R7 eleven timeouts");
    hold_cycles(18);
    check(1'b1, "R7 twelfth timeout");

    // R5 first edge after timeout is unjudged
    wave(16, 12);
    check(1'b1, "R5 edge after timeout not judged");
    wave(16, 1);
    check(1'b0, "R5 reacquire");

    // R7 sweep of invalid lengths while losing
    for (int p = 10; p <= 20; p++) begin
      if (p >= 15 && p <= 17) continue;
      do_reset(); wave(16, 13); wave(p, 14);
      check(1'b1, $sformatf("R7 lose length %0d", p));
    end

    // R8 valid cycle clears the invalid run
    do_reset(); wave(16, 13); wave(13, 11);
    check(1'b0, "R8 eleven invalid");
    wave(16, 1); wave(13, 11);
    check(1'b0, "R8 invalid run restarted");
    wave(13, 1);
    check(1'b1, "R7 twelve invalid after restart");

    // R8 invalid cycle clears the valid run
    do_reset(); wave(16, 12); wave(14, 1); wave(16, 11);
    check(1'b1, "R8 valid run restarted");
    wave(16, 1);
    check(1'b0, "R8 twelve valid after restart");

    // R2 hold and both-flag intervals create no extra edges
    do_reset(); gap_wave(13);
    check(1'b0, "R2 held intervals");

    // R1 reset clears counters and the detect flag
    do_reset(); wave(16, 12); do_reset(); wave(16, 12);
    check(1'b1, "R1 valid run cleared by reset");
    wave(16, 1);
    check(1'b0, "R1 detect after cleared run");
    do_reset(); hold_cycles(1);
    check(1'b1, "R1 reset while detected");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule